// File: doc/BRIEF.md
# DRAM Read Spacing Guard

This block watches the command stream of one DRAM channel (activates, reads and writes, each tagged with a rank and a bank). Every DRAM clock it answers one question: may a candidate READ to a given rank and bank go out now? A scheduler places its preferred read target on the candidate pins and gets the answer in the same cycle. The block also checks every READ that was actually issued and raises a flag one cycle later if that READ broke a spacing rule.

Five minimum spacings apply, all counted in DRAM clocks: activate to read on the same rank-bank, write to read on the same rank and on another rank, and read to read on the same rank and on another rank. They come from one 24-bit configuration word that resets to all zeros. The block keeps one saturating age counter per rank-bank for activates, and two per rank for writes and reads. It has no view of the data path, refresh, or the write and activate spacing rules.

The command input is a valid-qualified stream with no ready signal. The block never applies back-pressure: a command presented with `cmd_valid` high is taken as issued on that clock edge.

Top module: `rd_spacing_guard`

## Requirements
- R1: A READ at cycle t to rank-bank (r,b) is allowed only if an ACT to (r,b) was issued at some cycle e and t−e ≥ the activate-to-read field (config bits 20:17). A rank-bank that has never received an ACT since reset blocks reads.
- R2: A READ at cycle t to rank r is allowed only if t minus the cycle of the last WRITE to rank r is at least the same-rank write-to-read field (bits 16:12). A rank never written imposes no limit.
- R3: A READ to rank r is allowed only if, for every other rank q, t minus the cycle of the last WRITE to q is at least the different-rank write-to-read field (bits 11:8).
- R4: A READ to rank r is allowed only if t minus the cycle of the last READ to rank r is at least the same-rank read-to-read field (bits 7:4).
- R5: A READ to rank r is allowed only if, for every other rank q, t minus the cycle of the last READ to q is at least the different-rank read-to-read field (bits 3:0).
- R6: After reset the configuration reads back as zero, `rd_violation` is low, and no candidate is allowed until its rank-bank is activated.
- R7: Elapsed-time tracking saturates. A rank or bank left idle for any number of cycles beyond the largest field value stays unblocked and never wraps back into a blocked state.
- R8: A configuration write takes effect on the next cycle. `rd_allowed` and the violation check in the write cycle use the old fields, and `cfg_rdata` shows the new word from the next cycle on.
- R9: Bits 23:21 of the configuration are reserved. Writes to them are ignored and they always read as zero.
- R10: `rd_violation` is high in the cycle after an issued READ that broke R1–R5 rules as evaluated in its issue cycle, and low after any other cycle. Command kind encoding: 00 idle, 01 ACT, 10 READ, 11 WRITE.
- R11: `rd_allowed` is a same-cycle function of the candidate pins and the block's state, and is high only when every rule above is met.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | DRAM clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 24 | Configuration word to write |
| cfg_rdata | output | 24 | Current configuration word, reserved bits zero |
| cmd_valid | input | 1 | An issued command is present this cycle |
| cmd_kind | input | 2 | Command kind: 00 idle, 01 ACT, 10 READ, 11 WRITE |
| cmd_rank | input | $clog2(RANKS) | Rank of the issued command |
| cmd_bank | input | $clog2(BANKS) | Bank of the issued command |
| cand_rank | input | $clog2(RANKS) | Rank of the candidate READ |
| cand_bank | input | $clog2(BANKS) | Bank of the candidate READ |
| rd_allowed | output | 1 | Candidate READ meets every spacing rule this cycle |
| rd_violation | output | 1 | The READ issued last cycle broke a spacing rule |

## Verification
`rd_allowed` is combinational, so the bench drives each candidate after a falling edge and samples it a fraction of a nanosecond later in the same cycle. It models elapsed time as the difference between the current cycle number and the cycle in which the event was issued. `rd_violation` and `cfg_rdata` each pass through one register. The bench computes their expected values before the rising edge that captures the command or write and compares them at the following falling edge. In a cycle that carries a configuration write, candidate checks use the old fields, and the model switches to the new fields only after that edge.

// File: rtl/rdsp_pkg.sv
`timescale 1ns/1ps
package rdsp_pkg;

  typedef enum logic [1:0] {
    KIND_IDLE = 2'b00,
    KIND_ACT  = 2'b01,
    KIND_RD   = 2'b10,
    KIND_WR   = 2'b11
  } cmd_kind_e;

  localparam int CFG_W   = 24;
  localparam int USED_W  = 21;
  localparam int ACT_W   = 4;
  localparam int WRS_W   = 5;
  localparam int WRD_W   = 4;
  localparam int RDS_W   = 4;
  localparam int RDD_W   = 4;
  // Widest field decides the age counter width so saturation covers every limit.
  localparam int AGE_W   = WRS_W;
  localparam logic [CFG_W-1:0] CFG_USED_MASK = CFG_W'((1 << USED_W) - 1);

  // Packed order mirrors the configuration word bits 20:0.
  typedef struct packed {
    logic [ACT_W-1:0] act_rd;
    logic [WRS_W-1:0] wr_same;
    logic [WRD_W-1:0] wr_diff;
    logic [RDS_W-1:0] rd_same;
    logic [RDD_W-1:0] rd_diff;
  } gaps_t;

endpackage

// File: rtl/rdsp_cfg_reg.sv
`timescale 1ns/1ps
module rdsp_cfg_reg
  import rdsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output gaps_t            gaps
);

  gaps_t held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (we) begin
      held_q <= gaps_t'(wdata[USED_W-1:0]);
    end
  end

  assign gaps  = held_q;
  assign rdata = {{(CFG_W-USED_W){1'b0}}, held_q};

endmodule

// File: rtl/rdsp_age_timer.sv
`timescale 1ns/1ps
module rdsp_age_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  output logic         seen,
  output logic [W-1:0] age
);

  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0;
      age  <= '0;
    end else if (hit) begin
      seen <= 1'b1;
      age  <= W'(1);
    end else if (seen && age != TOP) begin
      age  <= age + W'(1);
    end
  end

endmodule

// File: rtl/rdsp_rule_eval.sv
`timescale 1ns/1ps
module rdsp_rule_eval
  import rdsp_pkg::*;
#(
  parameter int RANKS = 2,
  parameter int BANKS = 4,
  localparam int RW  = $clog2(RANKS),
  localparam int BW  = $clog2(BANKS),
  localparam int NRB = RANKS * BANKS
) (
  input  gaps_t                           gaps,
  input  logic [RW-1:0]                   rank,
  input  logic [BW-1:0]                   bank,
  input  logic [NRB-1:0]                  act_seen,
  input  logic [NRB-1:0][AGE_W-1:0]       act_age,
  input  logic [RANKS-1:0]                wr_seen,
  input  logic [RANKS-1:0][AGE_W-1:0]     wr_age,
  input  logic [RANKS-1:0]                rd_seen,
  input  logic [RANKS-1:0][AGE_W-1:0]     rd_age,
  output logic                            ok
);

  int               idx;
  logic             act_ok;
  logic             wr_ok;
  logic             rd_ok;
  logic [AGE_W-1:0] lim;

  always_comb begin
    idx    = int'(rank) * BANKS + int'(bank);
    act_ok = 1'b0;
    for (int i = 0; i < NRB; i++) begin
      if (i == idx) begin
        act_ok = act_seen[i] && (act_age[i] >= AGE_W'(gaps.act_rd));
      end
    end

    wr_ok = 1'b1;
    rd_ok = 1'b1;
    for (int q = 0; q < RANKS; q++) begin
      lim = (q == int'(rank)) ? AGE_W'(gaps.wr_same) : AGE_W'(gaps.wr_diff);
      if (wr_seen[q] && wr_age[q] < lim) wr_ok = 1'b0;
      lim = (q == int'(rank)) ? AGE_W'(gaps.rd_same) : AGE_W'(gaps.rd_diff);
      if (rd_seen[q] && rd_age[q] < lim) rd_ok = 1'b0;
    end

    ok = act_ok && wr_ok && rd_ok;
  end

endmodule

// File: rtl/rd_spacing_guard.sv
`timescale 1ns/1ps
module rd_spacing_guard
  import rdsp_pkg::*;
#(
  parameter int RANKS = 2,
  parameter int BANKS = 4,
  localparam int RW  = $clog2(RANKS),
  localparam int BW  = $clog2(BANKS),
  localparam int NRB = RANKS * BANKS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_kind,
  input  logic [RW-1:0]    cmd_rank,
  input  logic [BW-1:0]    cmd_bank,
  input  logic [RW-1:0]    cand_rank,
  input  logic [BW-1:0]    cand_bank,
  output logic             rd_allowed,
  output logic             rd_violation
);

  gaps_t                       gaps;
  logic [NRB-1:0]              act_hit;
  logic [NRB-1:0]              act_seen;
  logic [NRB-1:0][AGE_W-1:0]   act_age;
  logic [RANKS-1:0]            wr_hit;
  logic [RANKS-1:0]            wr_seen;
  logic [RANKS-1:0][AGE_W-1:0] wr_age;
  logic [RANKS-1:0]            rd_hit;
  logic [RANKS-1:0]            rd_seen;
  logic [RANKS-1:0][AGE_W-1:0] rd_age;
  logic                        issue_ok;
  logic                        is_act;
  logic                        is_rd;
  logic                        is_wr;
  int                          cmd_idx;

  rdsp_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .gaps  (gaps)
  );

  assign is_act = cmd_valid && (cmd_kind == KIND_ACT);
  assign is_rd  = cmd_valid && (cmd_kind == KIND_RD);
  assign is_wr  = cmd_valid && (cmd_kind == KIND_WR);

  always_comb begin
    cmd_idx = int'(cmd_rank) * BANKS + int'(cmd_bank);
    for (int i = 0; i < NRB; i++) begin
      act_hit[i] = is_act && (cmd_idx == i);
    end
    for (int q = 0; q < RANKS; q++) begin
      wr_hit[q] = is_wr && (int'(cmd_rank) == q);
      rd_hit[q] = is_rd && (int'(cmd_rank) == q);
    end
  end

  for (genvar i = 0; i < NRB; i++) begin : g_act_age
    rdsp_age_timer #(.W(AGE_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (act_hit[i]),
      .seen  (act_seen[i]),
      .age   (act_age[i])
    );
  end

  for (genvar q = 0; q < RANKS; q++) begin : g_rank_age
    rdsp_age_timer #(.W(AGE_W)) u_wr (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (wr_hit[q]),
      .seen  (wr_seen[q]),
      .age   (wr_age[q])
    );
    rdsp_age_timer #(.W(AGE_W)) u_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (rd_hit[q]),
      .seen  (rd_seen[q]),
      .age   (rd_age[q])
    );
  end

  rdsp_rule_eval #(.RANKS(RANKS), .BANKS(BANKS)) u_cand_eval (
    .gaps     (gaps),
    .rank     (cand_rank),
    .bank     (cand_bank),
    .act_seen (act_seen),
    .act_age  (act_age),
    .wr_seen  (wr_seen),
    .wr_age   (wr_age),
    .rd_seen  (rd_seen),
    .rd_age   (rd_age),
    .ok       (rd_allowed)
  );

  rdsp_rule_eval #(.RANKS(RANKS), .BANKS(BANKS)) u_issue_eval (
    .gaps     (gaps),
    .rank     (cmd_rank),
    .bank     (cmd_bank),
    .act_seen (act_seen),
    .act_age  (act_age),
    .wr_seen  (wr_seen),
    .wr_age   (wr_age),
    .rd_seen  (rd_seen),
    .rd_age   (rd_age),
    .ok       (issue_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_violation <= 1'b0;
    end else begin
      rd_violation <= is_rd && !issue_ok;
    end
  end

endmodule

// File: rtl/rdsp_guard_checker.sv
`timescale 1ns/1ps
module rdsp_guard_checker
  import rdsp_pkg::*;
#(
  parameter int RANKS = 2,
  parameter int BANKS = 4,
  localparam int RW = $clog2(RANKS),
  localparam int BW = $clog2(BANKS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             cmd_valid,
  input logic [1:0]       cmd_kind,
  input logic [RW-1:0]    cmd_rank,
  input logic [BW-1:0]    cmd_bank,
  input logic [RW-1:0]    cand_rank,
  input logic [BW-1:0]    cand_bank,
  input logic             rd_allowed,
  input logic             rd_violation
);

  assert_act_blocks_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == KIND_ACT && !cfg_we && cfg_rdata[20:17] >= 4'd2)
    |=> (({cand_rank, cand_bank} == $past({cmd_rank, cmd_bank})) -> !rd_allowed));

  assert_wr_same_blocks_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == KIND_WR && !cfg_we && cfg_rdata[16:12] >= 5'd2)
    |=> ((cand_rank == $past(cmd_rank)) -> !rd_allowed));

  assert_rd_same_blocks_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == KIND_RD && !cfg_we && cfg_rdata[7:4] >= 4'd2)
    |=> ((cand_rank == $past(cmd_rank)) -> !rd_allowed));

  assert_cfg_lands_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata == ($past(cfg_wdata) & CFG_USED_MASK)));

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[23:21] == 3'b000);

  assert_no_flag_without_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_kind == KIND_RD) |=> !rd_violation);

endmodule

bind rd_spacing_guard rdsp_guard_checker #(.RANKS(RANKS), .BANKS(BANKS)) u_guard_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .cfg_wdata    (cfg_wdata),
  .cfg_rdata    (cfg_rdata),
  .cmd_valid    (cmd_valid),
  .cmd_kind     (cmd_kind),
  .cmd_rank     (cmd_rank),
  .cmd_bank     (cmd_bank),
  .cand_rank    (cand_rank),
  .cand_bank    (cand_bank),
  .rd_allowed   (rd_allowed),
  .rd_violation (rd_violation)
);

// File: tb/test_rd_spacing_guard.sv
`timescale 1ns/1ps
module test_rd_spacing_guard;

  localparam int RANKS = 2;
  localparam int BANKS = 4;
  localparam int NRB   = RANKS * BANKS;
  localparam logic [1:0] K_IDLE = 2'b00;
  localparam logic [1:0] K_ACT  = 2'b01;
  localparam logic [1:0] K_RD   = 2'b10;
  localparam logic [1:0] K_WR   = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [23:0] cfg_wdata;
  logic [23:0] cfg_rdata;
  logic        cmd_valid;
  logic [1:0]  cmd_kind;
  logic [0:0]  cmd_rank;
  logic [1:0]  cmd_bank;
  logic [0:0]  cand_rank;
  logic [1:0]  cand_bank;
  logic        rd_allowed;
  logic        rd_violation;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Model state
  int cyc;
  bit act_s[NRB];
  int act_t[NRB];
  bit wr_s[RANKS];
  int wr_t[RANKS];
  bit rd_s[RANKS];
  int rd_t[RANKS];
  int g_act, g_wrs, g_wrd, g_rds, g_rdd;
  logic [31:0] lfsr = 32'h1234_5678;

  always #5 clk = ~clk;

  rd_spacing_guard #(.RANKS(RANKS), .BANKS(BANKS)) i_rd_spacing_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .cmd_valid    (cmd_valid),
    .cmd_kind     (cmd_kind),
    .cmd_rank     (cmd_rank),
    .cmd_bank     (cmd_bank),
    .cand_rank    (cand_rank),
    .cand_bank    (cand_bank),
    .rd_allowed   (rd_allowed),
    .rd_violation (rd_violation)
  );

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  function automatic bit exp_ok(input int r, input int b);
    bit ok;
    int idx;
    idx = r * BANKS + b;
    ok  = act_s[idx] && (cyc - act_t[idx] >= g_act);          // R1
    for (int q = 0; q < RANKS; q++) begin
      if (wr_s[q] && (cyc - wr_t[q] < ((q == r) ? g_wrs : g_wrd))) ok = 0; // R2 R3
      if (rd_s[q] && (cyc - rd_t[q] < ((q == r) ? g_rds : g_rdd))) ok = 0; // R4 R5
    end
    return ok;
  endfunction

  task automatic check_cands(input string tag);
    for (int r = 0; r < RANKS; r++) begin
      for (int b = 0; b < BANKS; b++) begin
        cand_rank = r[0:0];
        cand_bank = b[1:0];
        #0.3;
        chk(rd_allowed == exp_ok(r, b), tag, int'(rd_allowed), int'(exp_ok(r, b)));
      end
    end
  endtask

  // One clock cycle; entered and left just after a falling edge.
  task automatic step(input bit v, input logic [1:0] k, input int r, input int b,
                      input bit we, input logic [23:0] wd, input string tag);
    bit ev;
    cmd_valid = v;
    cmd_kind  = k;
    cmd_rank  = r[0:0];
    cmd_bank  = b[1:0];
    cfg_we    = we;
    cfg_wdata = wd;
    check_cands(tag);
    ev = v && (k == K_RD) && !exp_ok(r, b);
    @(posedge clk);
    if (v) begin
      if (k == K_ACT) begin act_s[r*BANKS+b] = 1; act_t[r*BANKS+b] = cyc; end
      if (k == K_WR)  begin wr_s[r] = 1; wr_t[r] = cyc; end
      if (k == K_RD)  begin rd_s[r] = 1; rd_t[r] = cyc; end
    end
    if (we) begin
      g_act = int'(wd[20:17]);
      g_wrs = int'(wd[16:12]);
      g_wrd = int'(wd[11:8]);
      g_rds = int'(wd[7:4]);
      g_rdd = int'(wd[3:0]);
    end
    cyc++;
    @(negedge clk);
    chk(rd_violation == ev, "R10 rd_violation", int'(rd_violation), int'(ev));
    if (we) chk(cfg_rdata == (wd & 24'h1F_FFFF), "R8/R9 cfg_rdata", int'(cfg_rdata),
                int'(wd & 24'h1F_FFFF));
    cmd_valid = 0;
    cfg_we    = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, K_IDLE, 0, 0, 0, 24'h0, tag);
  endtask

  task automatic set_cfg(input logic [23:0] wd, input string tag);
    step(0, K_IDLE, 0, 0, 1, wd, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog expired: actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_wdata = '0; cmd_valid = 0; cmd_kind = K_IDLE;
    cmd_rank = '0; cmd_bank = '0; cand_rank = '0; cand_bank = '0;
    cyc = 0; g_act = 0; g_wrs = 0; g_wrd = 0; g_rds = 0; g_rdd = 0;
    for (int i = 0; i < NRB; i++) begin act_s[i] = 0; act_t[i] = 0; end
    for (int q = 0; q < RANKS; q++) begin wr_s[q] = 0; wr_t[q] = 0; rd_s[q] = 0; rd_t[q] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R6: reset state
    chk(cfg_rdata == 24'h0, "R6 cfg_rdata after reset", int'(cfg_rdata), 0);
    chk(rd_violation == 1'b0, "R6 rd_violation after reset", int'(rd_violation), 0);
    check_cands("R6/R1 never-activated blocked");

    // R1: activate-to-read, field 20:17 = 5
    set_cfg(24'h0A_0000, "R1 cfg write");
    step(1, K_ACT, 1, 2, 0, 24'h0, "R1 act");
    idle(7, "R1 act-to-read window");
    step(1, K_RD, 1, 2, 0, 24'h0, "R1 read after window");
    step(1, K_RD, 1, 3, 0, 24'h0, "R1 read unactivated bank");

    // Activate everything, then clear the activate limit.
    for (int i = 0; i < NRB; i++) step(1, K_ACT, i / BANKS, i % BANKS, 0, 24'h0, "R1 act all");
    // R2/R3: same-rank write 9, other-rank write 3
    set_cfg(24'h00_9300, "R2/R3 cfg write");
    step(1, K_WR, 0, 1, 0, 24'h0, "R2/R3 write");
    idle(11, "R2/R3 write-to-read window");
    step(1, K_WR, 1, 0, 0, 24'h0, "R3 write other rank");
    step(1, K_RD, 0, 0, 0, 24'h0, "R3 early read");

    // R4/R5: same-rank read 6, other-rank read 2
    set_cfg(24'h00_0062, "R4/R5 cfg write");
    step(1, K_RD, 1, 0, 0, 24'h0, "R4/R5 read");
    idle(8, "R4/R5 read-to-read window");
    step(1, K_RD, 1, 1, 0, 24'h0, "R4 read same rank");
    step(1, K_RD, 0, 1, 0, 24'h0, "R5 read other rank");

    // R7: saturation with the largest same-rank write limit
    set_cfg(24'h01_F000, "R7 cfg write");
    step(1, K_WR, 0, 0, 0, 24'h0, "R7 write");
    idle(80, "R7 saturation");

    // R8/R9: write with reserved bits set; write cycle uses old fields
    step(1, K_WR, 1, 0, 0, 24'h0, "R8 write");
    set_cfg(24'hE0_0F00, "R8 old fields in write cycle");
    check_cands("R8 new fields next cycle");
    chk(cfg_rdata[23:21] == 3'b000, "R9 reserved bits", int'(cfg_rdata[23:21]), 0);
    idle(16, "R8/R9 after write");

    // R11 plus all rules: pseudo-random streams under several configurations
    for (int p = 0; p < 5; p++) begin
      logic [23:0] w;
      case (p)
        0: w = 24'hFF_FFFF;
        1: w = 24'h0A_5342;
        2: w = 24'h06_2211;
        3: w = 24'h00_0000;
        default: w = 24'h13_7A3C;
      endcase
      set_cfg(w, "R8 sweep cfg");
      for (int i = 0; i < 400; i++) begin
        lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
        step(lfsr[9] | lfsr[11], lfsr[1:0], int'(lfsr[4]), int'(lfsr[6:5]), 0, 24'h0,
             "R11 R1/R2/R3/R4/R5 sweep");
      end
    end

    finish_run();
  end

endmodule